// File: doc/BRIEF.md
# Sensor Status and Interrupt Controller

This block collects the events of a multi-channel inductive button sensor front end into one 8-bit status word and drives a single interrupt pin whose active level is selectable. The events are the per-channel button states, a per-conversion check of the signed channel results for the saturation codes, three error pulses, and a timeout raised when a button is held too long. Most status bits are sticky. One read strobe clears them and the pending interrupt.

The same read strobe takes a snapshot of the button states and all channel results. Later reads of those values therefore form a consistent set, even while the converters keep producing new data. Bit positions in the status word are fixed, because the register front end decodes them directly. The hold timeout is counted in clock cycles through a parameter, so the bench can use a short window in place of the real-time limit.

Top module: `sense_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x40, the pending interrupt is clear (the pin is high while `irq_active_high` is 0), and the snapshot outputs are all zero.
- R2: Status bit 7 becomes 1 on the clock edge after any bit of `btn_state` is 1, and it stays 1 until a status read.
- R3: A one-cycle pulse on `err_fsm`, `err_osc` or `err_reg` sets status bit 3, 2 or 0 respectively, and the bit stays set until a status read.
- R4: When `res_valid` is 1 and any channel result equals the largest positive code (0x7FF for 12 bits) or the most negative code (0x800), status bit 4 is set. A result one code inside either limit does not set it.
- R5: When a button has been 1 on more than `HOLD_CYCLES` consecutive sampling edges, status bit 1 is set on the (`HOLD_CYCLES`+1)th edge. The flag is raised once per press. A release restarts that channel's count from zero.
- R6: A cycle with `stat_rd` at 1 and no new event clears status bits 7, 4, 3, 2, 1 and 0 and the pending interrupt at the next edge.
- R7: An event in the same cycle as `stat_rd` leaves its status bit and the pending interrupt set after that edge.
- R8: Any event sets the pending interrupt. `irq_n_or_p` equals the pending state when `irq_active_high` is 1 and its inverse when `irq_active_high` is 0.
- R9: On a cycle with `stat_rd` at 1, `snap_btn` and `snap_data` capture `btn_state` and `chan_data` from that cycle. They hold those values until the next read.
- R10: Status bit 6 follows `core_ready` one edge later and is 1 out of reset. Status bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_state | input | NCH | Current button decision per channel |
| chan_data | input | NCH*DW | Signed channel results, channel 0 in the low bits |
| res_valid | input | 1 | Pulse marking a new set of channel results |
| err_fsm | input | 1 | Sequencer watchdog error pulse |
| err_osc | input | 1 | Oscillator start failure pulse |
| err_reg | input | 1 | Register integrity error pulse |
| core_ready | input | 1 | Core ready indication after an internal reset |
| stat_rd | input | 1 | Status read strobe, one cycle per read |
| irq_active_high | input | 1 | 0 selects an active-low pin, 1 selects an active-high pin |
| stat_word | output | 8 | Status word |
| irq_n_or_p | output | 1 | Interrupt pin |
| snap_btn | output | NCH | Button states latched at the last status read |
| snap_data | output | NCH*DW | Channel results latched at the last status read |

## Verification
Every status bit, the pending interrupt and the snapshot change on the first clock edge after their stimulus. The one exception is the timeout, which lands on the (`HOLD_CYCLES`+1)th edge of a continuous press. The interrupt pin is the pending register passed through combinational polarity logic, so a change of `irq_active_high` shows without any delay. The bench drives inputs on falling edges and samples one falling edge later, which places each check half a cycle after the edge that updates the result. For the timeout, the bench counts edges exactly: it checks that the flag is still clear after `HOLD_CYCLES` edges and set after one more.

// File: rtl/sense_status_pkg.sv
package sense_status_pkg;

  // Fixed bit positions of the status word (decoded by the register front end).
  localparam int unsigned SB_BTN   = 7;
  localparam int unsigned SB_READY = 6;
  localparam int unsigned SB_WRDY  = 5;
  localparam int unsigned SB_MAXC  = 4;
  localparam int unsigned SB_FSM   = 3;
  localparam int unsigned SB_OSC   = 2;
  localparam int unsigned SB_TMO   = 1;
  localparam int unsigned SB_REGF  = 0;

  // Sticky event set, one bit per clear-on-read status flag.
  typedef struct packed {
    logic btn;
    logic maxc;
    logic fsm;
    logic osc;
    logic tmo;
    logic regf;
  } sticky_t;

endpackage

// File: rtl/sense_rst_sync.sv
module sense_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sense_hold_timer.sv
module sense_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 32'd2500000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic expire_o
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign expire_o = btn_i && at_limit && !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!btn_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else begin
      if (!at_limit) cnt_d = cnt_q + 1'b1;
      if (expire_o)  done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R5: one expiry per press, and a release restarts the count.
  p_expire_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  p_release_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !btn_i |=> (cnt_q == '0) && !done_q);

endmodule

// File: rtl/sense_flag_bank.sv
module sense_flag_bank
  import sense_status_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sticky_t evt_i,
  input  logic    rd_i,
  input  logic    core_ready_i,
  output logic [7:0] word_o,
  output logic    pend_o
);

  sticky_t flags_q, flags_d;
  logic    pend_q, pend_d;
  logic    ready_q;
  logic    any_evt;

  assign any_evt = |evt_i;

  always_comb begin
    flags_d = rd_i ? '0 : flags_q;
    flags_d = flags_d | evt_i;
    pend_d  = (rd_i ? 1'b0 : pend_q) | any_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
      ready_q <= core_ready_i;
    end
  end

  always_comb begin
    word_o           = '0;
    word_o[SB_BTN]   = flags_q.btn;
    word_o[SB_READY] = ready_q;
    word_o[SB_WRDY]  = 1'b0;
    word_o[SB_MAXC]  = flags_q.maxc;
    word_o[SB_FSM]   = flags_q.fsm;
    word_o[SB_OSC]   = flags_q.osc;
    word_o[SB_TMO]   = flags_q.tmo;
    word_o[SB_REGF]  = flags_q.regf;
  end

  assign pend_o = pend_q;

  // R6: a quiet read empties every sticky flag and the pending interrupt.
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !any_evt) |=> (word_o[7] == 1'b0) && (word_o[4:0] == 5'd0) && !pend_o);
  // R7: an error arriving with a read survives it.
  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i.fsm) |=> word_o[SB_FSM] && pend_o);
  // R3: sticky error flags persist without a read.
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o[SB_REGF] && !rd_i) |=> word_o[SB_REGF]);
  // R10: ready bit tracks its input one edge later.
  p_ready_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> word_o[SB_READY] == $past(core_ready_i));

endmodule

// File: rtl/sense_snapshot.sv
module sense_snapshot #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [NCH-1:0]    btn_i,
  input  logic [NCH*DW-1:0] data_i,
  output logic [NCH-1:0]    snap_btn_o,
  output logic [NCH*DW-1:0] snap_data_o
);

  logic [NCH-1:0]    btn_q, btn_d;
  logic [NCH*DW-1:0] data_q, data_d;

  always_comb begin
    btn_d  = btn_q;
    data_d = data_q;
    if (rd_i) begin
      btn_d  = btn_i;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= '0;
      data_q <= '0;
    end else begin
      btn_q  <= btn_d;
      data_q <= data_d;
    end
  end

  assign snap_btn_o  = btn_q;
  assign snap_data_o = data_q;

  // R9: snapshot only moves on a read.
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(snap_data_o) && $stable(snap_btn_o));

endmodule

// File: rtl/sense_status_ctrl.sv
module sense_status_ctrl
  import sense_status_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned DW          = 12,
  parameter int unsigned HOLD_CYCLES = 32'd2500000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    btn_state,
  input  logic [NCH*DW-1:0] chan_data,
  input  logic              res_valid,
  input  logic              err_fsm,
  input  logic              err_osc,
  input  logic              err_reg,
  input  logic              core_ready,
  input  logic              stat_rd,
  input  logic              irq_active_high,
  output logic [7:0]        stat_word,
  output logic              irq_n_or_p,
  output logic [NCH-1:0]    snap_btn,
  output logic [NCH*DW-1:0] snap_data
);

  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic           rst_sync_n;
  logic [NCH-1:0] expire;
  logic [NCH-1:0] at_rail;
  sticky_t        evt;
  logic           pend;

  sense_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [DW-1:0] res;
    assign res         = chan_data[ch*DW +: DW];
    assign at_rail[ch] = (res == POS_MAX) || (res == NEG_MIN);

    sense_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .btn_i   (btn_state[ch]),
      .expire_o(expire[ch])
    );
  end

  always_comb begin
    evt.btn  = |btn_state;
    evt.maxc = res_valid && (|at_rail);
    evt.fsm  = err_fsm;
    evt.osc  = err_osc;
    evt.tmo  = |expire;
    evt.regf = err_reg;
  end

  sense_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_i       (evt),
    .rd_i        (stat_rd),
    .core_ready_i(core_ready),
    .word_o      (stat_word),
    .pend_o      (pend)
  );

  sense_snapshot #(.NCH(NCH), .DW(DW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_i       (stat_rd),
    .btn_i      (btn_state),
    .data_i     (chan_data),
    .snap_btn_o (snap_btn),
    .snap_data_o(snap_data)
  );

  assign irq_n_or_p = irq_active_high ? pend : ~pend;

  // R8: any event leaves the pin at its active level on the next edge.
  p_irq_active_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|evt && $stable(irq_active_high)) |=> (irq_n_or_p == irq_active_high));
  // R4: a rail code with a valid result raises the saturation flag.
  p_rail_flag_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && |at_rail) |=> stat_word[SB_MAXC]);
  // R2: a pressed button shows in bit 7 on the next edge.
  p_btn_flag_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|btn_state) |=> stat_word[SB_BTN]);

endmodule

// File: tb/sense_status_ctrl_tb.sv
module sense_status_ctrl_tb;

  localparam int unsigned NCH  = 4;
  localparam int unsigned DW   = 12;
  localparam int unsigned HOLD = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    btn_state;
  logic [NCH*DW-1:0] chan_data;
  logic              res_valid, err_fsm, err_osc, err_reg;
  logic              core_ready, stat_rd, irq_active_high;
  logic [7:0]        stat_word;
  logic              irq_n_or_p;
  logic [NCH-1:0]    snap_btn;
  logic [NCH*DW-1:0] snap_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sense_status_ctrl #(.NCH(NCH), .DW(DW), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_state(btn_state), .chan_data(chan_data),
    .res_valid(res_valid), .err_fsm(err_fsm), .err_osc(err_osc), .err_reg(err_reg),
    .core_ready(core_ready), .stat_rd(stat_rd), .irq_active_high(irq_active_high),
    .stat_word(stat_word), .irq_n_or_p(irq_n_or_p), .snap_btn(snap_btn),
    .snap_data(snap_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 word", stat_word, 8'h40);
    chk("R1 pin", irq_n_or_p, 1'b1);
    chk("R1 snap", {snap_btn, snap_data}, '0);
  endtask

  task automatic t_button();
    btn_state = 4'b0001;
    step();
    chk("R2 bit7 set", stat_word[7], 1'b1);
    chk("R8 pin low active", irq_n_or_p, 1'b0);
    btn_state = 4'b0000;
    step(2);
    chk("R2 bit7 sticky", stat_word[7], 1'b1);
    do_read();
    chk("R6 cleared", stat_word, 8'h40);
    chk("R6 pin idle", irq_n_or_p, 1'b1);
  endtask

  task automatic t_errors();
    err_fsm = 1'b1; step(); err_fsm = 1'b0;
    chk("R3 fsm", stat_word, 8'h48);
    err_osc = 1'b1; err_reg = 1'b1; step(); err_osc = 1'b0; err_reg = 1'b0;
    step(3);
    chk("R3 all errors sticky", stat_word, 8'h4D);
    do_read();
    chk("R6 errors cleared", stat_word, 8'h40);
  endtask

  task automatic t_same_cycle();
    err_reg = 1'b1; stat_rd = 1'b1;
    step();
    err_reg = 1'b0; stat_rd = 1'b0;
    chk("R7 event kept", stat_word, 8'h41);
    chk("R7 irq kept", irq_n_or_p, 1'b0);
    do_read();
    chk("R7 cleared later", stat_word, 8'h40);
  endtask

  task automatic t_maxout();
    chan_data = '0;
    chan_data[2*DW +: DW] = 12'h7FE;
    chan_data[1*DW +: DW] = 12'h801;
    res_valid = 1'b1; step(); res_valid = 1'b0;
    chk("R4 inside rails", stat_word[4], 1'b0);
    chan_data[2*DW +: DW] = 12'h7FF;
    step();
    chk("R4 no valid no flag", stat_word[4], 1'b0);
    res_valid = 1'b1; step(); res_valid = 1'b0;
    chk("R4 positive rail", stat_word[4], 1'b1);
    do_read();
    chan_data[2*DW +: DW] = 12'h000;
    chan_data[1*DW +: DW] = 12'h800;
    res_valid = 1'b1; step(); res_valid = 1'b0;
    chk("R4 negative rail", stat_word[4], 1'b1);
    chan_data = '0;
    do_read();
  endtask

  task automatic t_timeout();
    btn_state = 4'b1000;
    step(HOLD);
    chk("R5 not yet at limit", stat_word[1], 1'b0);
    step();
    chk("R5 timeout set", stat_word[1], 1'b1);
    step(3);
    btn_state = 4'b0000;
    step();
    do_read();
    chk("R5 cleared by read", stat_word[1], 1'b0);
    btn_state = 4'b1000;
    step(HOLD);
    btn_state = 4'b0000;
    step();
    btn_state = 4'b1000;
    step(HOLD);
    chk("R5 release restarts count", stat_word[1], 1'b0);
    btn_state = 4'b0000;
    step();
    do_read();
  endtask

  task automatic t_polarity();
    irq_active_high = 1'b1;
    step();
    chk("R8 idle high-pol", irq_n_or_p, 1'b0);
    err_osc = 1'b1; step(); err_osc = 1'b0;
    chk("R8 active high", irq_n_or_p, 1'b1);
    do_read();
    chk("R8 cleared high-pol", irq_n_or_p, 1'b0);
    irq_active_high = 1'b0;
    step();
  endtask

  task automatic t_snapshot();
    btn_state = 4'b0101;
    chan_data = {12'hABC, 12'h123, 12'hF00, 12'h055};
    do_read();
    btn_state = 4'b0010;
    chan_data = {12'h111, 12'h222, 12'h333, 12'h444};
    step(2);
    chk("R9 snap btn", snap_btn, 4'b0101);
    chk("R9 snap data", snap_data, {12'hABC, 12'h123, 12'hF00, 12'h055});
    do_read();
    chk("R9 second read", snap_data, {12'h111, 12'h222, 12'h333, 12'h444});
    btn_state = '0;
    chan_data = '0;
    step();
    do_read();
  endtask

  task automatic t_ready();
    core_ready = 1'b0;
    step();
    chk("R10 ready low", stat_word[6], 1'b0);
    chk("R10 bit5 zero", stat_word[5], 1'b0);
    core_ready = 1'b1;
    step();
    chk("R10 ready high", stat_word[6], 1'b1);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; btn_state = '0; chan_data = '0; res_valid = 1'b0;
    err_fsm = 1'b0; err_osc = 1'b0; err_reg = 1'b0; core_ready = 1'b1;
    stat_rd = 1'b0; irq_active_high = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_button();
    t_errors();
    t_same_cycle();
    t_maxout();
    t_timeout();
    t_polarity();
    t_snapshot();
    t_ready();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule